// File: doc/BRIEF.md
# 8-bit Arithmetic/Logic Unit with Packed-Decimal Add and Subtract

This block is the purely combinational arithmetic and logic datapath of a small 8-bit processor. Each evaluation takes an operation code, a register operand, a memory operand, and the processor's current carry and decimal-mode flags. It produces an 8-bit result, new values for the negative (N), zero (Z), carry (C) and overflow (V) flags, and one update enable per flag. The enables tell the surrounding sequencer which flags the operation is allowed to change.

Add and subtract work in plain binary or in packed BCD, depending on the decimal flag. In decimal mode each nibble is corrected. For add, C and V come from the corrected sum. For subtract, they come from the binary intermediate value. Compare and bit-test leave the register operand on the result bus and follow their own flag rules. Shifts, rotates, increment and decrement act on the memory operand. For accumulator forms, the sequencer routes the accumulator onto that input.

A parameter `DECIMAL_EN` controls the decimal paths. When it is set to 0, the decimal paths are not built and the decimal input has no effect.

Top module: `alu8_core`

## Requirements
- R1: With opcode 0 (add) and the decimal input low, the 9-bit value {C, result} equals register + memory + carry-in. V is set when bit 7 of the result differs from bit 7 of both operands. All four flag enables are high.
- R2: With opcode 0 and the decimal input high, the add proceeds in these steps:
  - The low nibbles and carry-in are summed. If that sum exceeds 9, 10 is taken off and bit 4 is forced on.
  - Both high nibbles, in place, are then added.
  - If the total exceeds 0x9F, 0x60 is added.
  - The result is the low 8 bits of the total. C is set when the total exceeds 0xFF. V uses the R1 rule on this corrected result.
- R3: With opcode 1 (subtract) and the decimal input low, the result is the low byte of register − memory − 1 + carry-in. C is set when that value is not negative. V is bit 7 of (register xor value) AND (register xor memory). All four enables are high.
- R4: With opcode 1 and the decimal input high, the subtract proceeds in these steps:
  - The low digit is register low nibble − memory low nibble − 1 + carry-in, and the high digit is the difference of the high nibbles.
  - If the low digit is negative, it loses 6 more and the high digit is decremented.
  - If the high digit is then negative, it loses 6.
  - The result is {high digit[3:0], low digit[3:0]}. C and V are the binary values of R3.
- R5: Opcode 2 (compare) drives the register operand to the result. C is set when register ≥ memory, unsigned. N and Z come from the 8-bit difference register − memory. Only the N, Z and C enables are high.
- R6: Opcode 6 (bit test) drives the register operand to the result. Z is set when (register AND memory) is zero, N equals memory bit 7 and V equals memory bit 6. Only the N, Z and V enables are high.
- R7: Opcodes 3, 4 and 5 give register AND, OR and XOR memory respectively, with only the N and Z enables high.
- R8: Opcode 7 shifts the memory operand left and opcode 8 shifts it right. A zero enters the vacated bit and the bit shifted out goes to C. The N, Z and C enables are high.
- R9: Opcode 9 rotates the memory operand left and opcode 10 rotates it right. Carry-in enters the vacated bit and the bit shifted out goes to C. The N, Z and C enables are high.
- R10: Opcode 11 gives memory + 1 and opcode 12 gives memory − 1, both modulo 256, with only the N and Z enables high.
- R11: For every operation other than compare and bit test, whenever N or Z is enabled, N equals result bit 7 and Z is set exactly when the result is zero.
- R12: A flag whose enable is low is driven to 0. Opcodes 13 to 15 drive the register operand to the result with all four enables low.
- R13: The decimal input changes only opcodes 0 and 1; every other operation gives the same outputs whichever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (encodings in R1–R12) |
| opa_i | input | 8 | Register operand |
| opb_i | input | 8 | Memory operand (source of shifts, increment, decrement) |
| carry_i | input | 1 | Incoming carry flag |
| decimal_i | input | 1 | Decimal-mode flag |
| result_o | output | 8 | Operation result |
| neg_o | output | 1 | New N flag |
| zero_o | output | 1 | New Z flag |
| carry_o | output | 1 | New C flag |
| ovf_o | output | 1 | New V flag |
| neg_upd_o | output | 1 | N update enable |
| zero_upd_o | output | 1 | Z update enable |
| carry_upd_o | output | 1 | C update enable |
| ovf_upd_o | output | 1 | V update enable |

## Verification
The bench builds the block with `DECIMAL_EN` at its default of 1, so the nibble-correction paths for add and subtract are present. With the decimal input randomised alongside the opcode, both those paths and the rule that decimal mode leaves every other operation alone are exercised. Directed vectors target the decimal wrap from 99 to 00, the borrow from 00 to 99 and non-decimal nibble inputs. They also cover signed overflow at 0x7F/0x80, compare on equal operands, and increment and decrement across the 8-bit wrap.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
  localparam int DATA_W    = 8;
  localparam int NIB_W     = DATA_W / 2;
  localparam int OP_W      = 4;
  localparam int DIGIT_MAX = 9;
  localparam int LO_FIX    = 10;
  localparam int HI_LIMIT  = 'h9F;
  localparam int HI_FIX    = 'h60;
  localparam int SUB_FIX   = 6;
  localparam int BYTE_MAX  = (1 << DATA_W) - 1;
  localparam int MSB       = DATA_W - 1;

  typedef logic [DATA_W-1:0] data_t;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_CMP = 4'd2,  OP_AND = 4'd3,
    OP_OR  = 4'd4,  OP_XOR = 4'd5,  OP_BIT = 4'd6,  OP_ASL = 4'd7,
    OP_LSR = 4'd8,  OP_ROL = 4'd9,  OP_ROR = 4'd10, OP_INC = 4'd11,
    OP_DEC = 4'd12, OP_RS0 = 4'd13, OP_RS1 = 4'd14, OP_RS2 = 4'd15
  } alu_op_e;

  typedef struct packed {
    data_t res;
    logic  n;
    logic  z;
    logic  c;
    logic  v;
  } alu_out_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flag_en_t;

  // Derive N and Z from the result byte.
  function automatic alu_out_t set_nz(alu_out_t x);
    alu_out_t y;
    y   = x;
    y.n = x.res[MSB];
    y.z = (x.res == '0);
    return y;
  endfunction

  function automatic alu_out_t add_bin(data_t a, data_t m, logic ci);
    alu_out_t r;
    logic [DATA_W:0] s;
    s     = {1'b0, a} + {1'b0, m} + {{DATA_W{1'b0}}, ci};
    r     = '0;
    r.res = s[DATA_W-1:0];
    r.c   = s[DATA_W];
    r.v   = (a[MSB] ^ s[MSB]) & (m[MSB] ^ s[MSB]);
    return set_nz(r);
  endfunction

  // Packed-decimal add: low digit fixed first, then the upper digit.
  function automatic alu_out_t add_dec(data_t a, data_t m, logic ci);
    alu_out_t r;
    int lo;
    int t;
    lo = int'(a[NIB_W-1:0]) + int'(m[NIB_W-1:0]) + int'(ci);
    if (lo > DIGIT_MAX) lo = (lo - LO_FIX) | (1 << NIB_W);
    t = lo + int'({a[DATA_W-1:NIB_W], {NIB_W{1'b0}}})
           + int'({m[DATA_W-1:NIB_W], {NIB_W{1'b0}}});
    if (t > HI_LIMIT) t = t + HI_FIX;
    r     = '0;
    r.res = t[DATA_W-1:0];
    r.c   = (t > BYTE_MAX);
    r.v   = (a[MSB] ^ r.res[MSB]) & (m[MSB] ^ r.res[MSB]);
    return set_nz(r);
  endfunction

  function automatic alu_out_t sub_bin(data_t a, data_t m, logic ci);
    alu_out_t r;
    logic [DATA_W:0] d;
    d     = {1'b0, a} - {1'b0, m} - {{DATA_W{1'b0}}, 1'b1}
          + {{DATA_W{1'b0}}, ci};
    r     = '0;
    r.res = d[DATA_W-1:0];
    r.c   = ~d[DATA_W];
    r.v   = (a[MSB] ^ d[MSB]) & (a[MSB] ^ m[MSB]);
    return set_nz(r);
  endfunction

  // Packed-decimal subtract: C and V stay those of the binary value.
  function automatic alu_out_t sub_dec(data_t a, data_t m, logic ci);
    alu_out_t r;
    int lo;
    int hi;
    r  = sub_bin(a, m, ci);
    lo = int'(a[NIB_W-1:0]) - int'(m[NIB_W-1:0]) - 1 + int'(ci);
    hi = int'(a[DATA_W-1:NIB_W]) - int'(m[DATA_W-1:NIB_W]);
    if ((lo & (1 << NIB_W)) != 0) begin
      lo = lo - SUB_FIX;
      hi = hi - 1;
    end
    if ((hi & (1 << NIB_W)) != 0) hi = hi - SUB_FIX;
    r.res = {hi[NIB_W-1:0], lo[NIB_W-1:0]};
    return set_nz(r);
  endfunction

  function automatic alu_out_t cmp_calc(data_t a, data_t m);
    alu_out_t r;
    logic [DATA_W:0] d;
    d     = {1'b0, a} - {1'b0, m};
    r     = '0;
    r.res = a;
    r.n   = d[MSB];
    r.z   = (d[DATA_W-1:0] == '0);
    r.c   = ~d[DATA_W];
    return r;
  endfunction
endpackage

// File: rtl/alu8_arith.sv
`timescale 1ns/1ps
module alu8_arith import alu8_pkg::*; #(
  parameter bit DECIMAL_EN = 1'b1
) (
  input  alu_op_e  op,
  input  data_t    a,
  input  data_t    m,
  input  logic     ci,
  input  logic     dec,
  output alu_out_t q,
  output logic     dec_path
);
  alu_out_t add_b, sub_b, cmp_r, add_d, sub_d;

  assign add_b = add_bin(a, m, ci);
  assign sub_b = sub_bin(a, m, ci);
  assign cmp_r = cmp_calc(a, m);

  generate
    if (DECIMAL_EN) begin : g_dec
      assign add_d    = add_dec(a, m, ci);
      assign sub_d    = sub_dec(a, m, ci);
      assign dec_path = dec;
    end else begin : g_bin_only
      logic unused_dec;
      assign unused_dec = dec;
      assign add_d      = add_b;
      assign sub_d      = sub_b;
      assign dec_path   = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_ADD:  q = dec_path ? add_d : add_b;
      OP_SUB:  q = dec_path ? sub_d : sub_b;
      OP_CMP:  q = cmp_r;
      default: q = '0;
    endcase
  end
endmodule

// File: rtl/alu8_logic.sv
`timescale 1ns/1ps
module alu8_logic import alu8_pkg::*; (
  input  alu_op_e  op,
  input  data_t    a,
  input  data_t    m,
  output alu_out_t q
);
  always_comb begin
    q = '0;
    unique case (op)
      OP_AND: begin q.res = a & m; q = set_nz(q); end
      OP_OR:  begin q.res = a | m; q = set_nz(q); end
      OP_XOR: begin q.res = a ^ m; q = set_nz(q); end
      OP_BIT: begin
        q.res = a;
        q.z   = ((a & m) == '0);
        q.n   = m[MSB];
        q.v   = m[MSB-1];
      end
      default: q = '0;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
`timescale 1ns/1ps
module alu8_shift import alu8_pkg::*; (
  input  alu_op_e  op,
  input  data_t    m,
  input  logic     ci,
  output alu_out_t q
);
  // Bit that fills the vacated position: zero for shifts, carry for rotates.
  logic fill_bit;
  assign fill_bit = (op == OP_ROL || op == OP_ROR) ? ci : 1'b0;

  always_comb begin
    q = '0;
    unique case (op)
      OP_ASL, OP_ROL: begin
        q.res = {m[DATA_W-2:0], fill_bit};
        q.c   = m[MSB];
        q     = set_nz(q);
      end
      OP_LSR, OP_ROR: begin
        q.res = {fill_bit, m[DATA_W-1:1]};
        q.c   = m[0];
        q     = set_nz(q);
      end
      OP_INC: begin q.res = m + 1'b1; q = set_nz(q); end
      OP_DEC: begin q.res = m - 1'b1; q = set_nz(q); end
      default: q = '0;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
`timescale 1ns/1ps
module alu8_core import alu8_pkg::*; #(
  parameter bit DECIMAL_EN = 1'b1
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              carry_i,
  input  logic              decimal_i,
  output logic [DATA_W-1:0] result_o,
  output logic              neg_o,
  output logic              zero_o,
  output logic              carry_o,
  output logic              ovf_o,
  output logic              neg_upd_o,
  output logic              zero_upd_o,
  output logic              carry_upd_o,
  output logic              ovf_upd_o
);
  alu_op_e  op;
  alu_out_t arith_q, logic_q, shift_q, pick;
  flag_en_t en;
  logic     sel_arith, sel_logic, sel_shift, op_unused;
  logic     dec_path;

  assign op = alu_op_e'(op_i);

  alu8_arith #(.DECIMAL_EN(DECIMAL_EN)) u_arith (
    .op(op), .a(opa_i), .m(opb_i), .ci(carry_i), .dec(decimal_i),
    .q(arith_q), .dec_path(dec_path)
  );

  alu8_logic u_logic (.op(op), .a(opa_i), .m(opb_i), .q(logic_q));

  alu8_shift u_shift (.op(op), .m(opb_i), .ci(carry_i), .q(shift_q));

  // Operation class and flag update enables.
  always_comb begin
    sel_arith = 1'b0;
    sel_logic = 1'b0;
    sel_shift = 1'b0;
    op_unused = 1'b0;
    en        = '0;
    unique case (op)
      OP_ADD, OP_SUB: begin sel_arith = 1'b1; en = 4'b1111; end
      OP_CMP:         begin sel_arith = 1'b1; en = 4'b1110; end
      OP_AND, OP_OR, OP_XOR:
                      begin sel_logic = 1'b1; en = 4'b1100; end
      OP_BIT:         begin sel_logic = 1'b1; en = 4'b1101; end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR:
                      begin sel_shift = 1'b1; en = 4'b1110; end
      OP_INC, OP_DEC: begin sel_shift = 1'b1; en = 4'b1100; end
      default:        begin op_unused = 1'b1; en = 4'b0000; end
    endcase
  end

  always_comb begin
    pick     = '0;
    pick.res = opa_i;
    if (sel_arith)      pick = arith_q;
    else if (sel_logic) pick = logic_q;
    else if (sel_shift) pick = shift_q;
  end

  assign result_o    = pick.res;
  assign neg_o       = pick.n & en.n;
  assign zero_o      = pick.z & en.z;
  assign carry_o     = pick.c & en.c;
  assign ovf_o       = pick.v & en.v;
  assign neg_upd_o   = en.n;
  assign zero_upd_o  = en.z;
  assign carry_upd_o = en.c;
  assign ovf_upd_o   = en.v;
endmodule

// File: rtl/alu8_core_chk.sv
`timescale 1ns/1ps
module alu8_core_chk (
  input logic [3:0] op_i,
  input logic [7:0] opa_i,
  input logic [7:0] opb_i,
  input logic       carry_i,
  input logic       decimal_i,
  input logic [7:0] result_o,
  input logic       neg_o,
  input logic       zero_o,
  input logic       carry_o,
  input logic       ovf_o,
  input logic       neg_upd_o,
  input logic       zero_upd_o,
  input logic       carry_upd_o,
  input logic       ovf_upd_o,
  input logic       sel_arith,
  input logic       sel_logic,
  input logic       sel_shift,
  input logic       op_unused
);
  logic [8:0] bin_sum;
  assign bin_sum = {1'b0, opa_i} + {1'b0, opb_i} + {8'd0, carry_i};

  always_comb begin
    // R12: exactly one operation class is active
    a_r12_one_class: assert ($onehot({sel_arith, sel_logic, sel_shift, op_unused}))
      else $error("class select not one-hot");
    // R12: reserved codes pass the register and touch no flag
    if (op_i >= 4'd13)
      a_r12_reserved_quiet: assert (result_o == opa_i && !neg_upd_o && !zero_upd_o
                                    && !carry_upd_o && !ovf_upd_o)
        else $error("reserved opcode not quiet");
    // R12: disabled flags read as zero
    a_r12_masked_zero: assert ((neg_upd_o || !neg_o) && (zero_upd_o || !zero_o)
                               && (carry_upd_o || !carry_o) && (ovf_upd_o || !ovf_o))
      else $error("disabled flag driven high");
    // R1: binary add sum and carry
    if (op_i == 4'd0 && !decimal_i)
      a_r1_binary_sum: assert ({carry_o, result_o} == bin_sum)
        else $error("binary add mismatch");
    // R5: compare keeps the register and carries the unsigned order
    if (op_i == 4'd2)
      a_r5_cmp_order: assert (result_o == opa_i && carry_o == (opa_i >= opb_i) && !ovf_upd_o)
        else $error("compare mismatch");
    // R6: bit test copies memory bits 7 and 6
    if (op_i == 4'd6)
      a_r6_bit_copy: assert (neg_o == opb_i[7] && ovf_o == opb_i[6]
                             && zero_o == ((opa_i & opb_i) == 8'd0) && !carry_upd_o)
        else $error("bit test mismatch");
    // R7 and R10: logic, increment and decrement leave C and V alone
    if (op_i inside {4'd3, 4'd4, 4'd5, 4'd11, 4'd12})
      a_r7_nz_only: assert (!carry_upd_o && !ovf_upd_o && neg_upd_o && zero_upd_o)
        else $error("nz-only op enables wrong");
    // R11: N and Z track the result
    if ((neg_upd_o || zero_upd_o) && op_i != 4'd2 && op_i != 4'd6)
      a_r11_nz_result: assert (neg_o == result_o[7] && zero_o == (result_o == 8'd0))
        else $error("N/Z disagree with result");
  end
endmodule

bind alu8_core alu8_core_chk u_chk (
  .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i), .carry_i(carry_i),
  .decimal_i(decimal_i), .result_o(result_o), .neg_o(neg_o), .zero_o(zero_o),
  .carry_o(carry_o), .ovf_o(ovf_o), .neg_upd_o(neg_upd_o),
  .zero_upd_o(zero_upd_o), .carry_upd_o(carry_upd_o), .ovf_upd_o(ovf_upd_o),
  .sel_arith(sel_arith), .sel_logic(sel_logic), .sel_shift(sel_shift),
  .op_unused(op_unused)
);

// File: tb/alu8_core_tb_top.sv
`timescale 1ns/1ps
module alu8_core_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op;
  logic [7:0] opa, opb;
  logic       cin, dec;
  logic [7:0] res;
  logic       n, z, c, v, nu, zu, cu, vu;
  int         checks = 0;
  int         errors = 0;
  bit         done   = 1'b0;

  always #2.5 clk = ~clk;

  alu8_core dut_i (
    .op_i(op), .opa_i(opa), .opb_i(opb), .carry_i(cin), .decimal_i(dec),
    .result_o(res), .neg_o(n), .zero_o(z), .carry_o(c), .ovf_o(v),
    .neg_upd_o(nu), .zero_upd_o(zu), .carry_upd_o(cu), .ovf_upd_o(vu)
  );

  // Expected {result, N, Z, C, V, enN, enZ, enC, enV}, written from the requirements.
  function automatic logic [15:0] expect_of(logic [3:0] o, logic [7:0] a, logic [7:0] m,
                                            logic ci, logic d);
    logic [7:0] r;
    logic fn, fz, fc, fv;
    logic [3:0] en;
    int s, lo, hi, t;
    r = a; fn = 0; fz = 0; fc = 0; fv = 0; en = 4'b0000;
    case (o)
      4'd0: begin
        en = 4'b1111;
        if (d) begin
          lo = int'(a[3:0]) + int'(m[3:0]) + int'(ci);
          if (lo > 9) begin lo = lo - 10; if (lo < 16) lo = lo + 16; end
          t = lo + int'(a & 8'hF0) + int'(m & 8'hF0);
          if (t >= 160) t = t + 96;
          r = t[7:0]; fc = (t >= 256);
        end else begin
          s = int'(a) + int'(m) + int'(ci);
          r = s[7:0]; fc = (s >= 256);
        end
        fv = (r[7] != a[7]) && (r[7] != m[7]);
      end
      4'd1: begin
        en = 4'b1111;
        s  = int'(a) - int'(m) - 1 + int'(ci);
        fc = (s >= 0);
        fv = (a[7] != s[7]) && (a[7] != m[7]);
        if (d) begin
          lo = int'(a[3:0]) - int'(m[3:0]) - 1 + int'(ci);
          hi = int'(a[7:4]) - int'(m[7:4]);
          if (lo < 0) begin lo = lo - 6; hi = hi - 1; end
          if (hi < 0) hi = hi - 6;
          r = {hi[3:0], lo[3:0]};
        end else r = s[7:0];
      end
      4'd2: begin
        en = 4'b1110; s = int'(a) - int'(m);
        fn = s[7]; fz = (s[7:0] == 8'd0); fc = (a >= m);
      end
      4'd3: begin en = 4'b1100; r = a & m; end
      4'd4: begin en = 4'b1100; r = a | m; end
      4'd5: begin en = 4'b1100; r = a ^ m; end
      4'd6: begin en = 4'b1101; fz = ((a & m) == 0); fn = m[7]; fv = m[6]; end
      4'd7:  begin en = 4'b1110; r = m << 1; fc = m[7]; end
      4'd8:  begin en = 4'b1110; r = m >> 1; fc = m[0]; end
      4'd9:  begin en = 4'b1110; r = {m[6:0], ci}; fc = m[7]; end
      4'd10: begin en = 4'b1110; r = {ci, m[7:1]}; fc = m[0]; end
      4'd11: begin en = 4'b1100; r = m + 8'd1; end
      4'd12: begin en = 4'b1100; r = m - 8'd1; end
      default: ;
    endcase
    if (o != 4'd2 && o != 4'd6 && en[3]) begin
      fn = r[7]; fz = (r == 8'd0);
    end
    return {r, fn, fz, fc, fv, en};
  endfunction

  function automatic string tag_of(logic [3:0] o, logic d);
    case (o)
      4'd0: return d ? "R2" : "R1";
      4'd1: return d ? "R4" : "R3";
      4'd2: return "R5";
      4'd6: return "R6";
      4'd3, 4'd4, 4'd5: return "R7";
      4'd7, 4'd8: return "R8";
      4'd9, 4'd10: return "R9";
      4'd11, 4'd12: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic run_vec(logic [3:0] o, logic [7:0] a, logic [7:0] m, logic ci,
                         logic d, string tag);
    logic [15:0] got, exp;
    @(negedge clk);
    op = o; opa = a; opb = m; cin = ci; dec = d;
    @(posedge clk);
    #1;
    got = {res, n, z, c, v, nu, zu, cu, vu};
    exp = expect_of(o, a, m, ci, d);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%02h m=%02h c=%0b d=%0b actual=%04h expected=%04h",
               tag, o, a, m, ci, d, got, exp);
    end
  endtask

  initial begin
    int seed;
    op = 4'd15; opa = 8'h5A; opb = 8'h00; cin = 1'b0; dec = 1'b0;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    // R12: quiet outputs while idle on a reserved code during reset
    checks++;
    if ({res, n, z, c, v, nu, zu, cu, vu} !== {8'h5A, 8'h00}) begin
      errors++;
      $display("FAIL R12 reset idle actual=%04h expected=%04h",
               {res, n, z, c, v, nu, zu, cu, vu}, {8'h5A, 8'h00});
    end
    rst = 1'b0;

    run_vec(4'd0, 8'h7F, 8'h01, 1'b0, 1'b0, "R1 signed overflow");
    run_vec(4'd0, 8'hFF, 8'h00, 1'b1, 1'b0, "R1 carry wrap to zero");
    run_vec(4'd0, 8'h99, 8'h01, 1'b0, 1'b1, "R2 decimal 99+1");
    run_vec(4'd0, 8'h58, 8'h46, 1'b1, 1'b1, "R2 decimal carry");
    run_vec(4'd0, 8'hFF, 8'hFF, 1'b1, 1'b1, "R2 non-decimal nibbles");
    run_vec(4'd1, 8'h80, 8'h01, 1'b1, 1'b0, "R3 signed overflow");
    run_vec(4'd1, 8'h00, 8'h01, 1'b1, 1'b1, "R4 decimal 00-01");
    run_vec(4'd1, 8'h50, 8'h25, 1'b0, 1'b1, "R4 decimal borrow in");
    run_vec(4'd2, 8'h42, 8'h42, 1'b0, 1'b0, "R5 compare equal");
    run_vec(4'd2, 8'h10, 8'h20, 1'b1, 1'b1, "R5 compare below R13");
    run_vec(4'd6, 8'h0F, 8'hC0, 1'b0, 1'b0, "R6 bit test zero");
    run_vec(4'd10, 8'h00, 8'h01, 1'b1, 1'b0, "R9 rotate right");
    run_vec(4'd9, 8'h00, 8'h80, 1'b0, 1'b0, "R9 rotate left to zero");
    run_vec(4'd8, 8'h00, 8'h01, 1'b1, 1'b0, "R8 shift right ignores carry");
    run_vec(4'd11, 8'h00, 8'hFF, 1'b0, 1'b1, "R10 increment wrap R13");
    run_vec(4'd12, 8'h00, 8'h00, 1'b0, 1'b0, "R10 decrement wrap R11");
    run_vec(4'd14, 8'h33, 8'hFF, 1'b1, 1'b1, "R12 reserved code");

    for (int i = 0; i < 4000; i++) begin
      logic [3:0] ro;
      logic [7:0] ra, rm;
      logic rc, rd;
      ro = 4'($urandom_range(0, 15));
      ra = 8'($urandom);
      rm = 8'($urandom);
      rc = 1'($urandom);
      rd = 1'($urandom);
      run_vec(ro, ra, rm, rc, rd, tag_of(ro, rd));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule